// File: doc/BRIEF.md
# SPI Sensor ADC Command Responder

This block is the slave end of a sensor's serial digital readout. A master selects it with an active-low select line and clocks it in SPI mode 3 (clock idles high, data sampled on the rising edge), most significant bit first. Every transaction has two parts. First the master shifts in an 8-bit instruction. Then the block shifts out a 16-bit answer, for as long as the master keeps clocking and holding select low.

The block understands three instructions:

- a status read;
- a converter control word, which holds an enable bit and a channel bit;
- a result read.

It keeps the enable and channel bits and runs an 11-step successive-approximation sequencer. The sequencer sets the sample-hold output, then offers a trial code to an external DAC. It keeps or drops each trial bit according to an external comparator bit. When the last step is done, it raises end-of-conversion.

The block replies with a refusal word in three cases: an unknown opcode, a control word that arrives while a conversion is running, and any instruction that arrives during the start-up initialisation window. Raising select cuts the answer short. It never stops a conversion.

All SPI lines are resynchronised into the system clock domain. The SPI clock must therefore be at least eight times slower than the system clock.

Top module: `spi_adc_responder`

## Requirements
- R1: On each rising SCLK edge with select low, the block samples MOSI (MSB first) for the first 8 edges. After each falling edge that follows the 8th rising edge, it drives the next answer bit, bit 15 first. MISO is 0 while select is high and throughout the instruction phase.
- R2: Status read (opcode 0x88) answers with bit 15 = 0, bit 13 = end-of-conversion, bit 3 = channel and bit 2 = enable. All other bits are 0.
- R3: The control opcode is 0x90 with bit 3 = channel and bit 2 = enable. When accepted, it stores both bits and answers in the status layout with the updated values. If enable is 1, a conversion starts at the 8th rising SCLK edge: sample-hold asserts and end-of-conversion reads 0 in that same answer.
- R4: Result read (opcode 0x80) answers with bit 15 = 0, bit 13 = end-of-conversion, bits 11..1 = the last completed 11-bit result, and all other bits 0.
- R5: An unrecognised opcode is refused. The answer has bit 15 = 1, bit 14 = 1 and bit 13 = end-of-conversion.
- R6: A control instruction received while end-of-conversion is 0 is refused, with bit 15 = 1 and bit 14 = 0. The enable and channel bits stay unchanged and the running conversion completes.
- R7: For INIT_CYCLES clocks after reset, every instruction is refused with bit 10 = 1, and the block's state does not change.
- R8: Raising select part-way through an answer ends that answer. A conversion in progress still completes with the correct result.
- R9: While enable is 0, no conversion runs, sample-hold stays low and end-of-conversion stays 1.
- R10: The conversion resolves 11 bits MSB first, spending STEP_CYCLES clocks per bit. It keeps a trial bit when cmp_in is 1, so the result is the largest code whose DAC value the comparator accepts. chan_sel follows the stored channel bit.
- R11: After reset, enable = 0, channel = 0, end-of-conversion = 1, MISO = 0, sample-hold = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI clock, idles high |
| ss_n | input | 1 | SPI select, active low |
| mosi | input | 1 | Serial instruction input |
| miso | output | 1 | Serial answer output |
| cmp_in | input | 1 | Comparator decision, 1 = input at or above DAC level |
| dac_code | output | 11 | Current trial code for the DAC |
| chan_sel | output | 1 | Analog multiplexer channel select |
| sample_hold | output | 1 | Sample-and-hold acquire strobe |

## Verification
The bench goes after the following corner cases, each with the failure it would expose:

- A second control word sent while a conversion is running. A design that accepts it would restart the sequencer and clobber the enable and channel bits.
- A result read taken mid-conversion. A design that reports the wrong end-of-conversion bit here would let a polling master read a stale result.
- A control answer truncated after three bits. A design that ties conversion to select would lose the result.
- Instructions sent during the initialisation window, and control words with enable 0. A design that does not gate these would quietly start or reconfigure the converter.
- Extreme and alternating analog codes. These expose an MSB-first ordering error or a wrong keep/drop polarity in the sequencer.

// File: rtl/spi_adc_responder.sv
module spi_adc_responder #(
  parameter int INIT_CYCLES = 200,
  parameter int STEP_CYCLES = 16,
  parameter int RES_BITS    = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                ss_n,
  input  logic                mosi,
  output logic                miso,
  input  logic                cmp_in,
  output logic [RES_BITS-1:0] dac_code,
  output logic                chan_sel,
  output logic                sample_hold
);
  localparam int IW = $clog2(INIT_CYCLES + 2);
  localparam int CW = $clog2(STEP_CYCLES + 1);
  localparam int BW = $clog2(RES_BITS);

  logic [1:0] sclk_m, ss_m, mosi_m;
  logic       sclk_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_m <= 2'b11; ss_m <= 2'b11; mosi_m <= 2'b00; sclk_d <= 1'b1;
    end else begin
      sclk_m <= {sclk_m[0], sclk};
      ss_m   <= {ss_m[0], ss_n};
      mosi_m <= {mosi_m[0], mosi};
      sclk_d <= sclk_m[1];
    end

  wire rise = sclk_m[1] & ~sclk_d;
  wire fall = ~sclk_m[1] & sclk_d;
  wire sel  = ~ss_m[1];

  logic [IW-1:0] init_cnt;
  wire busy = init_cnt < IW'(INIT_CYCLES);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) init_cnt <= '0;
    else if (busy) init_cnt <= init_cnt + 1'b1;

  typedef enum logic [1:0] {S_IDLE, S_SAMP, S_STEP} seq_t;
  seq_t st;
  logic eoc;
  assign eoc = (st == S_IDLE);

  logic [4:0]  bitcnt;
  logic [6:0]  ins;
  logic [15:0] ans, word;
  logic        miso_q, aden, chan;
  logic [RES_BITS-1:0] trial, result, nt;
  logic [CW-1:0] tick;
  logic [BW-1:0] idx;

  wire [7:0] op      = {ins, mosi_m[1]};
  wire is_stat       = op == 8'h88;
  wire is_read       = op == 8'h80;
  wire is_ctl        = (op[7:4] == 4'h9) && (op[1:0] == 2'b00);
  wire known         = is_stat | is_read | is_ctl;
  wire refuse        = busy | ~known | (is_ctl & ~eoc);
  wire last_ins      = sel & rise & (bitcnt == 5'd7);
  wire ctl_ok        = last_ins & is_ctl & ~refuse;
  wire start         = ctl_ok & op[2];

  always_comb begin
    if (refuse)
      word = {1'b1, ~known, eoc, 2'b00, busy, 10'b0};
    else if (is_read)
      word = {2'b00, eoc, 1'b0, result, 1'b0};
    else if (is_ctl)
      word = {2'b00, ~op[2], 9'b0, op[3], op[2], 2'b00};
    else
      word = {2'b00, eoc, 9'b0, chan, aden, 2'b00};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bitcnt <= '0; ins <= '0; ans <= '0; miso_q <= 1'b0;
    end else if (!sel) begin
      bitcnt <= '0; miso_q <= 1'b0;
    end else if (rise) begin
      if (bitcnt < 5'd24) bitcnt <= bitcnt + 1'b1;
      if (bitcnt < 5'd7) ins <= {ins[5:0], mosi_m[1]};
      if (bitcnt == 5'd7) ans <= word;
    end else if (fall) begin
      if (bitcnt >= 5'd8 && bitcnt < 5'd24) begin
        miso_q <= ans[15];
        ans    <= {ans[14:0], 1'b0};
      end else miso_q <= 1'b0;
    end

  assign miso = ~ss_n & miso_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      aden <= 1'b0; chan <= 1'b0;
    end else if (ctl_ok) begin
      aden <= op[2]; chan <= op[3];
    end

  always_comb begin
    nt = trial;
    if (!cmp_in) nt[idx] = 1'b0;
    if (idx != '0) nt[idx - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; tick <= '0; idx <= '0; trial <= '0; result <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st <= S_SAMP; tick <= '0; trial <= '0;
        end
        S_SAMP: if (tick == CW'(STEP_CYCLES - 1)) begin
          st    <= S_STEP; tick <= '0;
          idx   <= BW'(RES_BITS - 1);
          trial <= RES_BITS'(1) << (RES_BITS - 1);
        end else tick <= tick + 1'b1;
        default: if (tick == CW'(STEP_CYCLES - 1)) begin
          tick  <= '0;
          trial <= nt;
          if (idx == '0) begin
            result <= nt; st <= S_IDLE;
          end else idx <= idx - 1'b1;
        end else tick <= tick + 1'b1;
      endcase
    end

  assign dac_code    = trial;
  assign chan_sel    = chan;
  assign sample_hold = (st == S_SAMP);

  // R9
  sleep_nosample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_hold |-> aden);
  // R7
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> eoc);
  // R6
  conv_cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |=> $stable(chan) && $stable(aden));
  // R3
  start_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> sample_hold && (chan_sel == $past(op[3])));
endmodule

// File: tb/tb_spi_adc_responder.sv
module tb_spi_adc_responder;
  localparam int H = 4;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b1, ss_n = 1'b1, mosi = 1'b0;
  logic miso, chan_sel, sample_hold, cmp_in;
  logic [10:0] dac_code, analog = '0;
  int checks = 0, fails = 0;
  bit done = 0, sh_seen = 0, ins_miso_bad = 0;

  always #2.5 clk = ~clk;
  assign cmp_in = (dac_code <= analog);
  always @(posedge clk) if (sample_hold) sh_seen = 1;

  spi_adc_responder #(.INIT_CYCLES(400), .STEP_CYCLES(64), .RES_BITS(11)) dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n), .mosi(mosi), .miso(miso),
    .cmp_in(cmp_in), .dac_code(dac_code), .chan_sel(chan_sel), .sample_hold(sample_hold));

  localparam logic [11:0] VEC [6] = '{12'h000, 12'hFFF, 12'h400, 12'h3FF, 12'hD55, 12'h2AA};

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] op, input int nans, input bit chk_start,
                      output logic [15:0] resp);
    resp = '0;
    ss_n = 1'b0; wt(H);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0; mosi = op[7-i]; wt(H);
      if (miso !== 1'b0) ins_miso_bad = 1;
      if (i == 7 && chk_start) chk("R3 sample_hold before 8th edge", {15'b0, sample_hold}, 16'h0);
      sclk = 1'b1; wt(H);
    end
    if (chk_start) chk("R3 sample_hold after 8th edge", {15'b0, sample_hold}, 16'h1);
    for (int j = 0; j < nans; j++) begin
      sclk = 1'b0; mosi = 1'b0; wt(H);
      resp[15-j] = miso;
      sclk = 1'b1; wt(H);
    end
    ss_n = 1'b1; mosi = 1'b0; wt(2*H);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [11:0] v;
    wt(5);
    chk("R11 reset outputs", {12'b0, miso, sample_hold, chan_sel, 1'b0}, 16'h0);
    rst_n = 1'b1; wt(2);
    // R7: busy window refusals, no state change
    xfer(8'h88, 6, 0, r); chk("R7 busy status refused", {r[15:10], 10'b0}, 16'hA400);
    xfer(8'h9C, 6, 0, r); chk("R7 busy control refused", {r[15:10], 10'b0}, 16'hA400);
    xfer(8'hFF, 6, 0, r); chk("R7 busy unknown refused", {r[15:10], 10'b0}, 16'hE400);
    chk("R7 channel unchanged", {15'b0, chan_sel}, 16'h0);
    wt(200);
    xfer(8'h88, 16, 0, r); chk("R11 R2 status after init", r, 16'h2000);
    xfer(8'h55, 16, 0, r); chk("R5 unknown opcode", r, 16'hE000);
    // table walk: R3 R4 R10
    for (int k = 0; k < 6; k++) begin
      v = VEC[k]; analog = v[10:0];
      xfer(8'h94 | {4'b0, v[11], 3'b0}, 16, 1, r);
      chk("R3 control answer", r, 16'h0004 | {12'b0, v[11], 3'b0});
      chk("R10 chan_sel", {15'b0, chan_sel}, {15'b0, v[11]});
      wt(900);
      xfer(8'h80, 16, 0, r);
      chk("R4 R10 result read", r, 16'h2000 | {4'b0, v[10:0], 1'b0});
    end
    chk("R1 miso low in instruction phase", {15'b0, ins_miso_bad}, 16'h0);
    // conversion in progress: R6 R8
    analog = 11'h3A5;
    xfer(8'h98, 16, 0, r); chk("R9 sleep with chan", r, 16'h2008);
    xfer(8'h9C, 3, 0, r); chk("R8 truncated control", {r[15:13], 13'b0}, 16'h0);
    xfer(8'h90, 6, 0, r); chk("R6 control refused while busy conv", {r[15:10], 10'b0}, 16'h8000);
    xfer(8'h88, 16, 0, r); chk("R2 status mid conversion", r, 16'h000C);
    xfer(8'h80, 3, 0, r); chk("R4 read mid conversion", {r[15:13], 13'b0}, 16'h0);
    wt(900);
    xfer(8'h80, 16, 0, r); chk("R8 R6 result after truncation", r, 16'h2000 | {4'b0, 11'h3A5, 1'b0});
    xfer(8'h88, 16, 0, r); chk("R6 state kept", r, 16'h200C);
    // R9: sleep
    xfer(8'h90, 16, 0, r); chk("R9 sleep answer", r, 16'h2000);
    sh_seen = 0; analog = 11'h111;
    xfer(8'h98, 16, 0, r); chk("R9 sleep chan answer", r, 16'h2008);
    wt(900);
    chk("R9 no sample in sleep", {15'b0, sh_seen}, 16'h0);
    xfer(8'h80, 16, 0, r); chk("R9 result unchanged", r, 16'h2000 | {4'b0, 11'h3A5, 1'b0});
    chk("R1 miso low when deselected", {15'b0, miso}, 16'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule